// File: doc/BRIEF.md
# Dual-Direction Universal Bus Transceiver

This block moves a parameterized data word (18 bits by default) between two bidirectional ports, A and B. Each direction has its own storage cell. The cell is transparent while its pass control is high, so the far port follows the near port. When the pass control drops, the cell keeps the last word that went through it. It also loads a new word on the rising edge of its own strobe, but only while the strobe enable (active low) is asserted. An active-low output enable per direction decides whether that direction drives the opposite port or releases it to high impedance.

All controls are sampled against a system clock `clk`. A rising strobe edge is found by comparing the strobe with its value at the previous `clk` edge. A captured word appears on the output after the `clk` edge that loads it. In pass mode the output follows the input within the same cycle. Each direction produces a data value and a drive enable, and the top level turns these into the tri-state ports.

Top module: `ubt_transceiver`

## Requirements
- R1: While `ab_pass` is 1 and `ab_oe_n` is 0, port B carries the value present on port A in the same cycle.
- R2: While `ab_pass` is 0 and no enabled rising strobe edge occurs, the A-to-B cell keeps its word and port B shows it unchanged.
- R3: With `ab_pass` at 0 and `ab_strobe_en_n` at 0, a `clk` edge at which `ab_strobe` is 1 and was 0 at the previous edge loads port A. Port B shows that word from that edge onward.
- R4: A rising strobe edge while `ab_strobe_en_n` is 1 leaves the stored word unchanged.
- R5: `ab_oe_n` = 0 drives port B. `ab_oe_n` = 1 releases port B to high impedance.
- R6: The B-to-A direction obeys R1 to R5 with its own controls (`ba_pass`, `ba_strobe`, `ba_strobe_en_n`, `ba_oe_n`), taking port B as input and driving port A.
- R7: When the pass control falls, the cell holds the last word passed through it, which is the input at the final `clk` edge with pass high.
- R8: A rising strobe edge while pass is high has no effect beyond pass mode: the output keeps tracking the input.
- R9: While `rst_n` is 0, both cells clear to zero and both ports are released. After reset, a held output reads zero.
- R10: Asserting both output enables at once is a bus contention condition and is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes and cells are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ab_pass | input | 1 | A-to-B pass control; 1 = transparent |
| ab_strobe | input | 1 | A-to-B capture strobe; rising edge loads |
| ab_strobe_en_n | input | 1 | A-to-B strobe enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_pass | input | 1 | B-to-A pass control; 1 = transparent |
| ba_strobe | input | 1 | B-to-A capture strobe; rising edge loads |
| ba_strobe_en_n | input | 1 | B-to-A strobe enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_io | inout | W (18) | Port A: input of A-to-B, driven by B-to-A |
| b_io | inout | W (18) | Port B: input of B-to-A, driven by A-to-B |

## Verification
On every cycle, the assertions check the cell's load, hold and falling-pass behaviour, the match between each driven port and its direction's output, and the absence of both drivers at once. Only the bench's scenarios can show the complete behaviour seen at the ports. These scenarios cover pass-through in the same cycle, strobes blocked by the enable, edges that arrive during pass mode, the release to high impedance, and the zero word left by reset. The bench checks all of these against an independent model of both directions on every cycle.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  typedef enum logic [1:0] {
    CELL_HOLD = 2'd0,
    CELL_PASS = 2'd1,
    CELL_EDGE = 2'd2
  } cell_mode_t;

  // Decide what a storage cell does at the next clk edge.
  function automatic cell_mode_t pick_mode(input logic pass, input logic rise,
                                           input logic en_n);
    if (pass)               return CELL_PASS;
    else if (rise && !en_n) return CELL_EDGE;
    else                    return CELL_HOLD;
  endfunction

endpackage

// File: rtl/ubt_rise_detect.sv
module ubt_rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/ubt_store_cell.sv
module ubt_store_cell #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pass,
  input  logic         rise,
  input  logic         en_n,
  input  logic         oe_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         drive
);
  import ubt_pkg::*;

  cell_mode_t   mode;
  logic         load;
  logic [W-1:0] q;

  assign mode = pick_mode(pass, rise, en_n);
  assign load = (mode != CELL_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end

  assign dout  = pass ? din : q;
  assign drive = rst_n & ~oe_n;

  // R3: an enabled edge in held mode captures the input
  a_r3_edge_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && rise && !en_n) |=> (q == $past(din)));

  // R2 / R4: no pass and no enabled edge keeps the word
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && !(rise && !en_n)) |=> $stable(q));

  // R7: when pass falls, the held word is the last one passed
  a_r7_pass_fall_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(pass)) |-> (q == $past(din)));
endmodule

// File: rtl/ubt_path.sv
module ubt_path #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pass,
  input  logic         strobe,
  input  logic         strobe_en_n,
  input  logic         oe_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         drive
);
  logic rise;

  ubt_rise_detect u_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (strobe),
    .rise (rise)
  );

  ubt_store_cell #(.W(W)) u_cell (
    .clk  (clk),
    .rst_n(rst_n),
    .pass (pass),
    .rise (rise),
    .en_n (strobe_en_n),
    .oe_n (oe_n),
    .din  (din),
    .dout (dout),
    .drive(drive)
  );
endmodule

// File: rtl/ubt_transceiver.sv
module ubt_transceiver #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ab_pass,
  input  logic         ab_strobe,
  input  logic         ab_strobe_en_n,
  input  logic         ab_oe_n,
  input  logic         ba_pass,
  input  logic         ba_strobe,
  input  logic         ba_strobe_en_n,
  input  logic         ba_oe_n,
  inout  wire  [W-1:0] a_io,
  inout  wire  [W-1:0] b_io
);
  logic [W-1:0] ab_data, ba_data;
  logic         ab_drive, ba_drive;

  ubt_path #(.W(W)) u_ab (
    .clk        (clk),
    .rst_n      (rst_n),
    .pass       (ab_pass),
    .strobe     (ab_strobe),
    .strobe_en_n(ab_strobe_en_n),
    .oe_n       (ab_oe_n),
    .din        (a_io),
    .dout       (ab_data),
    .drive      (ab_drive)
  );

  ubt_path #(.W(W)) u_ba (
    .clk        (clk),
    .rst_n      (rst_n),
    .pass       (ba_pass),
    .strobe     (ba_strobe),
    .strobe_en_n(ba_strobe_en_n),
    .oe_n       (ba_oe_n),
    .din        (b_io),
    .dout       (ba_data),
    .drive      (ba_drive)
  );

  assign b_io = ab_drive ? ab_data : {W{1'bz}};
  assign a_io = ba_drive ? ba_data : {W{1'bz}};

  // R5: a driven B port carries the A-to-B word
  a_r5_b_port_driven: assert property (@(posedge clk) disable iff (!rst_n)
    ab_drive |-> (b_io == ab_data));

  // R6: a driven A port carries the B-to-A word
  a_r6_a_port_driven: assert property (@(posedge clk) disable iff (!rst_n)
    ba_drive |-> (a_io == ba_data));

  // R10: both directions enabled means contention on both ports
  a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(ab_drive && ba_drive));

  // R9: nothing drives while reset is held
  always_comb begin
    if (!rst_n) a_r9_reset_release: assert (!ab_drive && !ba_drive);
  end
endmodule

// File: tb/tb_ubt_transceiver.sv
`timescale 1ns/1ps
module tb_ubt_transceiver;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ab_pass = 0, ab_strobe = 0, ab_en_n = 1, ab_oe_n = 1;
  logic ba_pass = 0, ba_strobe = 0, ba_en_n = 1, ba_oe_n = 1;
  logic [W-1:0] tb_a = '0, tb_b = '0;
  logic tb_drv_a = 1'b1, tb_drv_b = 1'b1;
  wire  [W-1:0] a_io, b_io;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] m_ab_q = '0, m_ba_q = '0;
  logic m_ab_prev = 0, m_ba_prev = 0;
  logic [W-1:0] a_val, b_val, ab_out, ba_out;

  always #2.5 clk = ~clk;

  assign a_io = tb_drv_a ? tb_a : {W{1'bz}};
  assign b_io = tb_drv_b ? tb_b : {W{1'bz}};

  ubt_transceiver #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .ab_pass(ab_pass), .ab_strobe(ab_strobe), .ab_strobe_en_n(ab_en_n), .ab_oe_n(ab_oe_n),
    .ba_pass(ba_pass), .ba_strobe(ba_strobe), .ba_strobe_en_n(ba_en_n), .ba_oe_n(ba_oe_n),
    .a_io(a_io), .b_io(b_io)
  );

  function automatic logic [W-1:0] cell_out(logic pass, logic [W-1:0] din, logic [W-1:0] q);
    return pass ? din : q;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compute the expected port values from the model and the bench drivers.
  task automatic model_eval();
    logic ab_on, ba_on;
    ab_on = rst_n && !ab_oe_n;
    ba_on = rst_n && !ba_oe_n;
    if (ba_on) begin
      b_val  = tb_b;
      ba_out = cell_out(ba_pass, b_val, m_ba_q);
      a_val  = ba_out;
      ab_out = cell_out(ab_pass, a_val, m_ab_q);
    end else begin
      a_val  = tb_a;
      ab_out = cell_out(ab_pass, a_val, m_ab_q);
      b_val  = ab_on ? ab_out : tb_b;
      ba_out = cell_out(ba_pass, b_val, m_ba_q);
    end
  endtask

  function automatic string ab_tag();
    if (!rst_n) return "R9";
    if (ab_pass && ab_strobe && !m_ab_prev) return "R8";
    if (ab_pass) return "R1";
    return "R2";
  endfunction

  // One cycle: inputs already set after a negedge; check, then update model at posedge.
  task automatic step(string tag_ab, string tag_ba);
    if (!ab_oe_n && !ba_oe_n) ba_oe_n = 1'b1;   // bench never causes contention (R10)
    tb_drv_a = !(rst_n && !ba_oe_n);
    tb_drv_b = !(rst_n && !ab_oe_n);
    #0.5;
    model_eval();
    if (rst_n && !ab_oe_n) check({tag_ab, " B port"}, b_io, ab_out);
    if (rst_n && !ba_oe_n) check({tag_ba, " A port"}, a_io, ba_out);
    #0.5;
    // R5 / R6: briefly release the bench driver on an undriven port, expect high impedance
    if (tb_drv_b) begin
      tb_drv_b = 1'b0; #0.2;
      check(rst_n ? "R5 B released" : "R9 B released", b_io, {W{1'bz}});
      tb_drv_b = 1'b1; #0.2;
    end
    if (tb_drv_a) begin
      tb_drv_a = 1'b0; #0.2;
      check(rst_n ? "R6 A released" : "R9 A released", a_io, {W{1'bz}});
      tb_drv_a = 1'b1; #0.2;
    end
    @(posedge clk);
    if (!rst_n) begin
      m_ab_q = '0; m_ba_q = '0; m_ab_prev = 0; m_ba_prev = 0;
    end else begin
      if (ab_pass || (ab_strobe && !m_ab_prev && !ab_en_n)) m_ab_q = a_val;
      if (ba_pass || (ba_strobe && !m_ba_prev && !ba_en_n)) m_ba_q = b_val;
      m_ab_prev = ab_strobe;
      m_ba_prev = ba_strobe;
    end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1207));
    @(negedge clk);
    // R9: reset releases both ports
    step("R9", "R9");
    step("R9", "R9");
    rst_n = 1'b1;
    // R9: held output after reset is zero
    ab_oe_n = 0; tb_a = 18'h2AAAA;
    step("R9 cleared", "R6");
    // R1: pass-through
    ab_pass = 1; tb_a = 18'h1234F; step("R1", "R6");
    tb_a = 18'h0F0F0; step("R1", "R6");
    // R8: rising strobe during pass
    ab_strobe = 1; ab_en_n = 0; tb_a = 18'h33333; step("R8", "R6");
    // R7: pass falls, hold last passed value
    ab_pass = 0; ab_strobe = 0; tb_a = 18'h00001; step("R7", "R6");
    tb_a = 18'h3FFFF; step("R2", "R6");
    // R4: edge blocked by enable
    ab_en_n = 1; ab_strobe = 1; step("R4", "R6");
    tb_a = 18'h15555; step("R4", "R6");
    // R3: enabled edge captures
    ab_strobe = 0; ab_en_n = 0; step("R2", "R6");
    ab_strobe = 1; tb_a = 18'h2C3A5; step("R2", "R6");
    tb_a = 18'h00000; step("R3", "R6");
    // R5: release B
    ab_oe_n = 1; step("R5", "R6");
    // R6: reverse direction, pass then capture
    ba_oe_n = 0; ba_pass = 1; tb_b = 18'h3A5A5; step("R5", "R6");
    ba_pass = 0; tb_b = 18'h11111; step("R5", "R6 R7");
    ba_en_n = 0; ba_strobe = 1; tb_b = 18'h22222; step("R5", "R6");
    tb_b = 18'h0; step("R5", "R6 R3");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      ab_pass   = ($urandom % 4) == 0;
      ab_strobe = $urandom;
      ab_en_n   = $urandom;
      ab_oe_n   = $urandom;
      ba_pass   = ($urandom % 4) == 0;
      ba_strobe = $urandom;
      ba_en_n   = $urandom;
      ba_oe_n   = $urandom;
      tb_a = W'($urandom);
      tb_b = W'($urandom);
      step(ab_tag(), "R6");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule